// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled by watching the pump-up and pump-down pulses of its phase-frequency detector. A fast sampling clock counts how many of its periods show either pulse active between two rising edges of the reference-divider output. That count is the phase error of one comparison cycle. A run of cycles with small error raises an active-high lock flag. Once the flag is up, only a cycle with a clearly large error takes it down. The gap between the entry limit and the exit limit gives hysteresis, so the flag does not chatter.

The run length needed to declare lock has two settings, picked by a precision-select input. The active-low reset is meant to be driven by the chip's power-down logic. It clears the flag and all history at once. The two error limits and the two run lengths are parameters given in sampling-clock periods. The pulse inputs and the reference-divider output pass through a synchronizer of fixed depth before they are measured.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst_n` is low, `lock` is 0 at once (asynchronously). After release, no earlier run of good cycles and no partial measurement is remembered.
- R2: The phase error of a cycle is the number of sampling-clock periods in which `pd_up` or `pd_dn` is high, counted between successive rising edges of `ref_div`. A period in which both are high counts once.
- R3: A cycle is good when its error is strictly below ENTER_LIM (default 3). An error equal to ENTER_LIM is not good.
- R4: With `prec_sel` = 0, `lock` rises after RUN_LO (default 3) consecutive good cycles.
- R5: With `prec_sel` = 1, `lock` rises after RUN_HI (default 5) consecutive good cycles, and not earlier.
- R6: While unlocked, a cycle that is not good restarts the run from zero. While locked, a cycle whose error is at least ENTER_LIM but not above EXIT_LIM (default 5) leaves `lock` high.
- R7: While locked, one cycle with error strictly above EXIT_LIM drops `lock`. An error equal to EXIT_LIM does not. After a drop, a new full run is needed.
- R8: The error count saturates at EXIT_LIM+1, so a pulse lasting a whole cycle always counts as a large error and never wraps to a small one.
- R9: The first rising edge of `ref_div` after reset only starts a measurement. The partial cycle before it is never judged.
- R10: `lock` changes only as the result of judging a completed cycle. It is stable between judgements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous clear, driven by power-down |
| pd_up | input | 1 | Pump-up pulse from the phase detector |
| pd_dn | input | 1 | Pump-down pulse from the phase detector |
| ref_div | input | 1 | Reference-divider output; its rising edge ends a cycle |
| prec_sel | input | 1 | 0: short run to lock, 1: long run to lock |
| lock | output | 1 | Lock flag, active high |

## Verification
A run counter that is wrong shows up as a lock flag that rises one or more comparison cycles too early or too late. An error count that is wrong shows up as the flag ignoring a large-error cycle, or reacting to one that sits in the hysteresis band. Either fault becomes visible within a few sampling clocks after the reference edge that ends the affected cycle. The bench therefore checks the flag once per comparison cycle, just before the next edge. It sweeps pulse widths on both sides of each limit for both precision settings. A missing arm-on-first-edge stage shows as lock arriving one cycle early after every reset.

// File: rtl/pld_pkg.sv
package pld_pkg;
  // A completed cycle counts toward lock when its error is strictly below the entry limit.
  function automatic logic err_small(input int unsigned err, input int unsigned lim);
    return err < lim;
  endfunction

  // A completed cycle breaks lock when its error is strictly above the exit limit.
  function automatic logic err_large(input int unsigned err, input int unsigned lim);
    return err > lim;
  endfunction

  // Number of consecutive small-error cycles needed before lock is declared.
  function automatic int unsigned run_need(input logic prec, input int unsigned lo,
                                           input int unsigned hi);
    return prec ? hi : lo;
  endfunction
endpackage

// File: rtl/pld_sync.sv
module pld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_a,
  input  logic dn_a,
  input  logic ref_a,
  output logic act_s,
  output logic ref_rise
);
  logic [2:0] pipe [STAGES];
  logic       ref_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= {ref_a, dn_a, up_a};
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= pipe[STAGES-1][2];

  assign act_s    = pipe[STAGES-1][0] | pipe[STAGES-1][1];
  assign ref_rise = pipe[STAGES-1][2] & ~ref_q;

  // R2
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise);
endmodule

// File: rtl/pld_meter.sv
module pld_meter #(
  parameter int EXIT_LIM = 5,
  localparam int CNT_W   = $clog2(EXIT_LIM + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_s,
  input  logic             ref_rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_err
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(EXIT_LIM + 1);

  logic [CNT_W-1:0] acc_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q    <= '0;
      armed_q  <= 1'b0;
      meas_vld <= 1'b0;
      meas_err <= '0;
    end else begin
      meas_vld <= ref_rise & armed_q;
      if (ref_rise) begin
        meas_err <= acc_q;
        armed_q  <= 1'b1;
        acc_q    <= act_s ? CNT_W'(1) : '0;
      end else if (act_s && acc_q != SAT_V) begin
        acc_q <= acc_q + 1'b1;
      end
    end

  // R8
  acc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= SAT_V);
  // R9
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |-> $past(ref_rise));
endmodule

// File: rtl/pld_judge.sv
module pld_judge #(
  parameter int ENTER_LIM = 3,
  parameter int EXIT_LIM  = 5,
  parameter int RUN_LO    = 3,
  parameter int RUN_HI    = 5,
  localparam int CNT_W    = $clog2(EXIT_LIM + 2),
  localparam int RUN_W    = $clog2(RUN_HI + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prec,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] err_i,
  output logic             lock_o
);
  import pld_pkg::*;

  logic [RUN_W-1:0] run_q;
  logic             good, bad, run_full;
  int unsigned      need;

  assign good     = err_small(int'(err_i), ENTER_LIM);
  assign bad      = err_large(int'(err_i), EXIT_LIM);
  assign need     = run_need(prec, RUN_LO, RUN_HI);
  assign run_full = (int'(run_q) + 1) >= int'(need);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else if (vld_i) begin
      if (lock_o) begin
        if (bad) lock_o <= 1'b0;
        run_q <= '0;
      end else if (good) begin
        if (run_full) begin
          lock_o <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(vld_i && good));
  // R7
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(vld_i && bad));
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(lock_o));
  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) < RUN_HI);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_LIM   = 3,
  parameter int EXIT_LIM    = 5,
  parameter int RUN_LO      = 3,
  parameter int RUN_HI      = 5,
  localparam int CNT_W      = $clog2(EXIT_LIM + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_up,
  input  logic pd_dn,
  input  logic ref_div,
  input  logic prec_sel,
  output logic lock
);
  logic             act_s, ref_rise, meas_vld;
  logic [CNT_W-1:0] meas_err;

  pld_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .up_a(pd_up), .dn_a(pd_dn), .ref_a(ref_div),
    .act_s(act_s), .ref_rise(ref_rise));

  pld_meter #(.EXIT_LIM(EXIT_LIM)) meter_i (
    .clk(clk), .rst_n(rst_n), .act_s(act_s), .ref_rise(ref_rise),
    .meas_vld(meas_vld), .meas_err(meas_err));

  pld_judge #(.ENTER_LIM(ENTER_LIM), .EXIT_LIM(EXIT_LIM),
              .RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) judge_i (
    .clk(clk), .rst_n(rst_n), .prec(prec_sel), .vld_i(meas_vld),
    .err_i(meas_err), .lock_o(lock));

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> !lock);
endmodule

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;
  localparam int ENTER = 3, EXIT = 5, RLO = 3, RHI = 5, PER = 32, PSTART = 10;

  logic clk = 0, rst_n = 0, pd_up = 0, pd_dn = 0, ref_div = 0, prec_sel = 0;
  wire  lock;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  bit   armed = 0, exp_lock = 0;
  int   run = 0, prev_err = 0;

  always #10 clk = ~clk;

  pll_lock_detect dut_i (.clk(clk), .rst_n(rst_n), .pd_up(pd_up), .pd_dn(pd_dn),
    .ref_div(ref_div), .prec_sel(prec_sel), .lock(lock));

  task automatic check(input bit got, input bit exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: lock=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Judge one finished cycle from the requirement rules.
  task automatic judge(input int err);
    int need;
    need = prec_sel ? RHI : RLO;
    if (!armed) begin armed = 1; return; end
    if (exp_lock) begin
      if (err > EXIT) begin exp_lock = 0; run = 0; end
    end else if (err < ENTER) begin
      run++;
      if (run >= need) begin exp_lock = 1; run = 0; end
    end else run = 0;
  endtask

  // One reference cycle: rising edge at slot 0, pulses from slot PSTART.
  task automatic cyc(input int up_w, input int dn_w, input int dn_off, input string req);
    int err = 0;
    judge(prev_err);
    for (int i = 0; i < PER; i++) begin
      bit u, d;
      @(negedge clk);
      u = (i >= PSTART) && (i < PSTART + up_w);
      d = (i >= PSTART + dn_off) && (i < PSTART + dn_off + dn_w);
      ref_div = (i < 8);
      pd_up = u;
      pd_dn = d;
      if (u || d) err++;
    end
    prev_err = err;
    check(lock, exp_lock, req);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_n = 0;
    #1 check(lock, 1'b0, req);
    armed = 0; exp_lock = 0; run = 0; prev_err = 0;
    ref_div = 0; pd_up = 0; pd_dn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lock, 1'b0, "R1 reset");
    rst_n = 1;
    // R9: first edge only arms; R4: lock after three good cycles
    cyc(0, 0, 0, "R9");
    cyc(0, 0, 0, "R9");
    cyc(1, 0, 0, "R4");
    cyc(2, 0, 0, "R4");
    cyc(0, 0, 0, "R4");
    cyc(5, 0, 0, "R7 equal exit limit");
    cyc(3, 0, 0, "R6 band while locked");
    cyc(0, 0, 0, "R7");
    cyc(6, 0, 0, "R7 above exit");
    cyc(2, 0, 0, "R7 drop");
    cyc(2, 0, 0, "R3");
    cyc(3, 0, 0, "R3 equal entry limit");
    cyc(0, 2, 0, "R6 run restarted");
    cyc(2, 2, 0, "R2 overlap counts once");
    cyc(1, 1, 1, "R2 both pulses");
    cyc(0, 0, 0, "R2");
    cyc(20, 0, 0, "R8 long pulse");
    cyc(0, 0, 0, "R8 saturation drop");
    cyc(0, 0, 0, "R8");
    do_reset("R1 power-down");
    prec_sel = 1;
    for (int k = 0; k < 8; k++) cyc(1, 0, 0, "R5");
    // Sweep widths for both precision settings.
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 9; w++) begin
        do_reset("R1 sweep");
        prec_sel = p[0];
        for (int k = 0; k < 8; k++) begin
          cyc(w, 0, 0, p == 0 ? "R4 sweep" : "R5 sweep");
        end
        cyc(0, w, 0, "R7 sweep");
        cyc(0, 0, 0, "R10 sweep");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule